// File: doc/BRIEF.md
# Paired-Bit Debug Control Enable Bank

This block holds the enable state for a set of debug controls, packed into a small number of 32-bit words. In the default paired encoding, every control takes two adjacent bits: the even bit means "enabled" and the odd bit just above it means "disabled". A single upset bit therefore shows up as an illegal pair, either both bits set or both clear. With pairing turned off, every bit is a plain enable. The enable words are driven straight out to the debug logic.

Software writes enable words and lock words through a simple write port and reads any word through a combinational read port. Two masks are captured from constant inputs while reset is held. The first is a permitted-enable mask: an enable write that tries to set a bit outside it is rejected whole, and a sticky error flag is raised. The second is a provisioning mask. A one-cycle pulse on the provisioning-entry input rewrites every enable word in one step: each enable bit is kept only where the mask allows it, all disable bits are first cleared, and each control left without its enable bit then gets its disable bit set, if the mask allows that disable bit.

Lock bits only accumulate. A locked enable bit ignores later writes until reset. The provisioning step still rewrites locked bits, because forcing controls off must not be blocked by software locks.

Top module: `dcu_pair_bank`

## Requirements
- R1: While reset is held, and on the first cycle after it, every enable word, every lock word and the error flag read zero.
- R2: An accepted enable write to an unlocked word is returned exactly by a read of that word on the cycle after the write, and it appears on `ctrl_en_o` at the same time.
- R3: An enable write whose data has any bit set outside the permitted-enable mask word at the same index changes no enable word. From the next cycle `err_o` is 1, and it stays 1 until reset.
- R4: A lock write ORs its data into the addressed lock word. Lock bits are never cleared except by reset.
- R5: On an accepted enable write, bits whose lock bit is set keep their old value, and unlocked bits take the written value.
- R6: On a provisioning-entry pulse, every enable word is ANDed with the provisioning mask restricted to the even (enable) bit positions. Every odd bit is cleared before the next step. With pairing off, all bit positions count as enable positions.
- R7: In paired mode, after the step of R6, each odd bit whose even neighbour below it is now clear is set when the provisioning mask has that odd bit set. Example: enable word 0x05050505 with mask 0xFFFFFFFF becomes 0xA5A5A5A5.
- R8: The two mask banks read back the values present on the mask inputs during the last reset. Later changes on those inputs, and writes to those banks, have no effect.
- R9: When a write and a provisioning-entry pulse fall in the same cycle, the write is discarded without setting the error flag, and only the provisioning step takes place.
- R10: Address bits [ADDR_W-1:ADDR_W-2] select the bank: 0 for enables, 1 for locks, 2 for the provisioning mask, 3 for the permitted-enable mask. The low bits select the word index. Word w is carried on bits [32w+31:32w] of every flat bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the masks are captured while it is high |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address: bank select on the top two bits, word index below |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read address, same layout as wr_addr |
| rd_data | output | 32 | Combinational read data |
| prov_enter | input | 1 | One-cycle pulse that starts the provisioning forced-disable step |
| prov_mask_in | input | NUM_WORDS*32 | Provisioning mask, captured during reset |
| dis_mask_in | input | NUM_WORDS*32 | Permitted-enable mask, captured during reset |
| ctrl_en_o | output | NUM_WORDS*32 | All enable words, flat |
| err_o | output | 1 | Sticky rejected-write flag |

## Verification
Every state change (an enable or lock update, the provisioning rewrite, the error flag) lands on the first rising edge after the stimulus. Reads are combinational, so the bench drives each input on a falling edge and samples the result on the next falling edge, one clock later. A behavioural model in the bench is updated on the same edge as the design, and it is compared with `ctrl_en_o` and `err_o` on every falling edge. Explicit reads with hand-computed values cover the corner cases: a rejected write, merging under locks, provisioning with both halves of the mask, and a write that collides with the pulse.

// File: rtl/dcu_pkg.sv
package dcu_pkg;

    localparam int WORD_W = 32;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        BANK_EN    = 2'd0,
        BANK_LOCK  = 2'd1,
        BANK_PMASK = 2'd2,
        BANK_DMASK = 2'd3
    } bank_e;

    typedef struct packed {
        logic  en_we;
        logic  lock_we;
        word_t data;
    } wr_cmd_t;

    // Bit positions that carry the "enabled" half of a control.
    function automatic word_t en_positions(input bit paired);
        word_t m;
        for (int b = 0; b < WORD_W; b++) begin
            m[b] = paired ? (b % 2 == 0) : 1'b1;
        end
        return m;
    endfunction

    // Bit positions that carry the "disabled" half of a control.
    function automatic word_t dis_positions(input bit paired);
        word_t m;
        for (int b = 0; b < WORD_W; b++) begin
            m[b] = paired ? (b % 2 == 1) : 1'b0;
        end
        return m;
    endfunction

    // Forced-disable step applied on provisioning entry.
    function automatic word_t prov_force(input word_t en, input word_t pm,
                                         input bit paired);
        word_t kept;
        word_t ep;
        ep   = en_positions(paired);
        kept = en & pm & ep;
        return kept | (((~kept & ep) << 1) & pm & dis_positions(paired));
    endfunction

    function automatic word_t merge_locked(input word_t old_v, input word_t new_v,
                                           input word_t lock);
        return (old_v & lock) | (new_v & ~lock);
    endfunction

endpackage

// File: rtl/dcu_wr_decode.sv
module dcu_wr_decode
    import dcu_pkg::*;
#(
    parameter int NUM_WORDS = 4,
    parameter int IDX_W     = 2,
    parameter int ADDR_W    = IDX_W + 2
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  word_t             wr_data,
    input  logic              prov_enter,
    input  word_t             dmask [NUM_WORDS],
    output wr_cmd_t           cmd   [NUM_WORDS],
    output logic              reject
);
    bank_e            bank;
    logic [IDX_W-1:0] idx;
    word_t            dmask_sel;
    logic             en_hit;
    logic             lock_hit;
    logic             bad_bits;

    assign bank     = bank_e'(wr_addr[ADDR_W-1 -: 2]);
    assign idx      = wr_addr[IDX_W-1:0];
    assign en_hit   = wr_en && !prov_enter && (bank == BANK_EN);
    assign lock_hit = wr_en && !prov_enter && (bank == BANK_LOCK);

    always_comb begin
        dmask_sel = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (idx == IDX_W'(w)) dmask_sel = dmask[w];
        end
    end

    assign bad_bits = |(wr_data & ~dmask_sel);
    assign reject   = en_hit && bad_bits;

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_cmd
        assign cmd[w].en_we   = en_hit && !bad_bits && (idx == IDX_W'(w));
        assign cmd[w].lock_we = lock_hit && (idx == IDX_W'(w));
        assign cmd[w].data    = wr_data;
    end
endmodule

// File: rtl/dcu_word_slice.sv
module dcu_word_slice
    import dcu_pkg::*;
#(
    parameter bit PAIRED = 1'b1
) (
    input  logic    clk,
    input  logic    rst,
    input  wr_cmd_t cmd,
    input  logic    prov_enter,
    input  word_t   pmask,
    output word_t   en_q,
    output word_t   lock_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            lock_q <= '0;
        end else begin
            if (prov_enter) begin
                en_q <= prov_force(en_q, pmask, PAIRED);
            end else if (cmd.en_we) begin
                en_q <= merge_locked(en_q, cmd.data, lock_q);
            end
            if (cmd.lock_we) begin
                lock_q <= lock_q | cmd.data;
            end
        end
    end
endmodule

// File: rtl/dcu_rd_mux.sv
module dcu_rd_mux
    import dcu_pkg::*;
#(
    parameter int NUM_WORDS = 4,
    parameter int IDX_W     = 2,
    parameter int ADDR_W    = IDX_W + 2
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  word_t             en_w   [NUM_WORDS],
    input  word_t             lock_w [NUM_WORDS],
    input  word_t             pm_w   [NUM_WORDS],
    input  word_t             dm_w   [NUM_WORDS],
    output word_t             rd_data
);
    bank_e            bank;
    logic [IDX_W-1:0] idx;

    assign bank = bank_e'(rd_addr[ADDR_W-1 -: 2]);
    assign idx  = rd_addr[IDX_W-1:0];

    always_comb begin
        rd_data = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (idx == IDX_W'(w)) begin
                case (bank)
                    BANK_EN:    rd_data = en_w[w];
                    BANK_LOCK:  rd_data = lock_w[w];
                    BANK_PMASK: rd_data = pm_w[w];
                    default:    rd_data = dm_w[w];
                endcase
            end
        end
    end
endmodule

// File: rtl/dcu_pair_bank.sv
module dcu_pair_bank
    import dcu_pkg::*;
#(
    parameter int  NUM_WORDS = 4,
    parameter bit  PAIRED    = 1'b1,
    localparam int IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
    localparam int ADDR_W    = IDX_W + 2,
    localparam int FLAT_W    = NUM_WORDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    input  logic              prov_enter,
    input  logic [FLAT_W-1:0] prov_mask_in,
    input  logic [FLAT_W-1:0] dis_mask_in,
    output logic [FLAT_W-1:0] ctrl_en_o,
    output logic              err_o
);
    word_t   pm_q   [NUM_WORDS];
    word_t   dm_q   [NUM_WORDS];
    word_t   en_w   [NUM_WORDS];
    word_t   lock_w [NUM_WORDS];
    wr_cmd_t cmd    [NUM_WORDS];
    logic    reject;

    logic [FLAT_W-1:0] lock_flat;
    logic [FLAT_W-1:0] pm_flat;
    logic [FLAT_W-1:0] dm_flat;

    // Masks are captured only while reset is asserted.
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_mask
        always_ff @(posedge clk) begin
            if (rst) begin
                pm_q[w] <= prov_mask_in[w*WORD_W +: WORD_W];
                dm_q[w] <= dis_mask_in[w*WORD_W +: WORD_W];
            end
        end
        assign pm_flat[w*WORD_W +: WORD_W]   = pm_q[w];
        assign dm_flat[w*WORD_W +: WORD_W]   = dm_q[w];
        assign lock_flat[w*WORD_W +: WORD_W] = lock_w[w];
        assign ctrl_en_o[w*WORD_W +: WORD_W] = en_w[w];
    end

    dcu_wr_decode #(
        .NUM_WORDS (NUM_WORDS),
        .IDX_W     (IDX_W),
        .ADDR_W    (ADDR_W)
    ) u_dec (
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .prov_enter (prov_enter),
        .dmask      (dm_q),
        .cmd        (cmd),
        .reject     (reject)
    );

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        dcu_word_slice #(
            .PAIRED (PAIRED)
        ) u_slice (
            .clk        (clk),
            .rst        (rst),
            .cmd        (cmd[w]),
            .prov_enter (prov_enter),
            .pmask      (pm_q[w]),
            .en_q       (en_w[w]),
            .lock_q     (lock_w[w])
        );
    end

    dcu_rd_mux #(
        .NUM_WORDS (NUM_WORDS),
        .IDX_W     (IDX_W),
        .ADDR_W    (ADDR_W)
    ) u_rd (
        .rd_addr (rd_addr),
        .en_w    (en_w),
        .lock_w  (lock_w),
        .pm_w    (pm_q),
        .dm_w    (dm_q),
        .rd_data (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst)         err_o <= 1'b0;
        else if (reject) err_o <= 1'b1;
    end
endmodule

// File: rtl/dcu_pair_bank_chk.sv
module dcu_pair_bank_chk
    import dcu_pkg::*;
#(
    parameter int NUM_WORDS = 4,
    parameter bit PAIRED    = 1'b1,
    parameter int IDX_W     = 2,
    parameter int ADDR_W    = IDX_W + 2
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        wr_en,
    input logic [ADDR_W-1:0]           wr_addr,
    input logic [WORD_W-1:0]           wr_data,
    input logic                        prov_enter,
    input logic [NUM_WORDS*WORD_W-1:0] ctrl_en_o,
    input logic                        err_o,
    input logic [NUM_WORDS*WORD_W-1:0] lock_flat,
    input logic [NUM_WORDS*WORD_W-1:0] pm_flat,
    input logic [NUM_WORDS*WORD_W-1:0] dm_flat
);
    localparam int FLAT_W = NUM_WORDS * WORD_W;

    function automatic word_t pick(input logic [FLAT_W-1:0] f,
                                   input logic [IDX_W-1:0] i);
        word_t r;
        r = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (i == IDX_W'(w)) r = f[w*WORD_W +: WORD_W];
        end
        return r;
    endfunction

    logic [FLAT_W-1:0] ep_all;
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_ep
        assign ep_all[w*WORD_W +: WORD_W] = en_positions(PAIRED);
    end

    logic [IDX_W-1:0] idx;
    logic             en_wr;
    logic             bad;
    assign idx   = wr_addr[IDX_W-1:0];
    assign en_wr = wr_en && !prov_enter && (wr_addr[ADDR_W-1 -: 2] == 2'd0);
    assign bad   = |(wr_data & ~pick(dm_flat, idx));

    // R1
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (ctrl_en_o == '0 && lock_flat == '0 && !err_o));

    // R2
    a_r2_write_readback: assert property (@(posedge clk) disable iff (rst)
        (en_wr && !bad && pick(lock_flat, idx) == '0)
        |=> (pick(ctrl_en_o, $past(idx)) == $past(wr_data)));

    // R3
    a_r3_reject_hold: assert property (@(posedge clk) disable iff (rst)
        (en_wr && bad) |=> ($stable(ctrl_en_o) && err_o));

    a_r3_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);

    // R4
    a_r4_lock_monotonic: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((lock_flat & $past(lock_flat)) == $past(lock_flat)));

    // R5
    a_r5_locked_hold: assert property (@(posedge clk) disable iff (rst)
        !prov_enter |=> (((ctrl_en_o ^ $past(ctrl_en_o)) & $past(lock_flat)) == '0));

    // R6
    a_r6_prov_clear: assert property (@(posedge clk) disable iff (rst)
        prov_enter |=> ((ctrl_en_o & ~(pm_flat & ep_all)) & ep_all) == '0);

    // R7
    if (PAIRED) begin : g_pair_chk
        a_r7_prov_pairs: assert property (@(posedge clk) disable iff (rst)
            prov_enter |=> (((ctrl_en_o >> 1) & ep_all)
                            == (~ctrl_en_o & ep_all & (pm_flat >> 1))));
    end

    // R8
    a_r8_mask_stable: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($stable(pm_flat) && $stable(dm_flat)));
endmodule

bind dcu_pair_bank dcu_pair_bank_chk #(
    .NUM_WORDS (NUM_WORDS),
    .PAIRED    (PAIRED),
    .IDX_W     (IDX_W),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .prov_enter (prov_enter),
    .ctrl_en_o  (ctrl_en_o),
    .err_o      (err_o),
    .lock_flat  (lock_flat),
    .pm_flat    (pm_flat),
    .dm_flat    (dm_flat)
);

// File: tb/sim_dcu_pair_bank.sv
module sim_dcu_pair_bank;
    localparam int NW = 4;
    localparam int AW = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [AW-1:0]     wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic [AW-1:0]     rd_addr = '0;
    logic [31:0]       rd_data;
    logic              prov_enter = 1'b0;
    logic [NW*32-1:0]  prov_mask_in;
    logic [NW*32-1:0]  dis_mask_in;
    logic [NW*32-1:0]  ctrl_en_o;
    logic              err_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    dcu_pair_bank u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .prov_enter(prov_enter), .prov_mask_in(prov_mask_in),
        .dis_mask_in(dis_mask_in), .ctrl_en_o(ctrl_en_o), .err_o(err_o)
    );

    // Behavioural reference model
    logic [31:0] m_en [NW];
    logic [31:0] m_lk [NW];
    logic [31:0] m_pm [NW];
    logic [31:0] m_dm [NW];
    bit          m_err;

    always @(posedge clk) begin
        int bank;
        int ix;
        bank = int'(wr_addr[3:2]);
        ix   = int'(wr_addr[1:0]);
        if (rst) begin
            for (int w = 0; w < NW; w++) begin
                m_en[w] = 0;
                m_lk[w] = 0;
                m_pm[w] = prov_mask_in[w*32 +: 32];
                m_dm[w] = dis_mask_in[w*32 +: 32];
            end
            m_err = 0;
        end else if (prov_enter) begin
            for (int w = 0; w < NW; w++) begin
                for (int p = 0; p < 16; p++) begin
                    bit ev;
                    ev = m_en[w][2*p] && m_pm[w][2*p];
                    m_en[w][2*p]   = ev;
                    m_en[w][2*p+1] = !ev && m_pm[w][2*p+1];
                end
            end
        end else if (wr_en) begin
            if (bank == 0) begin
                if ((wr_data & ~m_dm[ix]) != 0) m_err = 1;
                else begin
                    for (int b = 0; b < 32; b++)
                        if (!m_lk[ix][b]) m_en[ix][b] = wr_data[b];
                end
            end else if (bank == 1) begin
                m_lk[ix] = m_lk[ix] | wr_data;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            for (int w = 0; w < NW; w++) begin
                checks++;
                if (ctrl_en_o[w*32 +: 32] !== m_en[w]) begin
                    fails++;
                    $display("FAIL R2 model word %0d ctrl_en actual %h expected %h",
                             w, ctrl_en_o[w*32 +: 32], m_en[w]);
                end
            end
            checks++;
            if (err_o !== m_err) begin
                fails++;
                $display("FAIL R3 model err actual %b expected %b", err_o, m_err);
            end
        end
    end

    task automatic wr(input int bank, input int ix, input logic [31:0] d, input bit prov);
        @(negedge clk);
        wr_en      = 1'b1;
        wr_addr    = AW'(bank * 4 + ix);
        wr_data    = d;
        prov_enter = prov;
        @(negedge clk);
        wr_en      = 1'b0;
        prov_enter = 1'b0;
    endtask

    task automatic pulse_prov();
        @(negedge clk);
        prov_enter = 1'b1;
        @(negedge clk);
        prov_enter = 1'b0;
    endtask

    task automatic rd_chk(input int bank, input int ix, input logic [31:0] exp, input string tag);
        rd_addr = AW'(bank * 4 + ix);
        #1;
        checks++;
        if (rd_data !== exp) begin
            fails++;
            $display("FAIL %s bank %0d word %0d actual %h expected %h",
                     tag, bank, ix, rd_data, exp);
        end
    endtask

    task automatic bit_chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %b expected %b", tag, act, exp);
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        dis_mask_in  = {32'hFFFFFFFF, 32'hFFFF0000, 32'h0F0F0F0F, 32'hFFFFFFFF};
        prov_mask_in = {32'h55555555, 32'hAAAAAAAA, 32'hFFFFFFFF, 32'h0000FFFF};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        for (int w = 0; w < NW; w++) begin
            rd_chk(0, w, 32'h0, "R1 enable");
            rd_chk(1, w, 32'h0, "R1 lock");
        end
        bit_chk(err_o, 1'b0, "R1 err");

        // R2 / R10: accepted writes read back exactly
        wr(0, 0, 32'h12345678, 0);
        rd_chk(0, 0, 32'h12345678, "R2 word0");
        wr(0, 2, 32'hFFFF0000, 0);
        rd_chk(0, 2, 32'hFFFF0000, "R2 word2");
        wr(0, 3, 32'hFFFFFFFF, 0);
        rd_chk(0, 3, 32'hFFFFFFFF, "R10 enable bank word3");
        rd_chk(1, 3, 32'h0, "R10 lock bank word3");

        // R3: rejected write
        wr(0, 1, 32'h10000000, 0);
        rd_chk(0, 1, 32'h0, "R3 word1 unchanged");
        rd_chk(0, 0, 32'h12345678, "R3 word0 unchanged");
        bit_chk(err_o, 1'b1, "R3 err set");
        wr(0, 1, 32'h05050505, 0);
        rd_chk(0, 1, 32'h05050505, "R2 word1 after reject");
        bit_chk(err_o, 1'b1, "R3 err sticky");

        // R4 / R5: locks
        wr(1, 0, 32'h0000FFFF, 0);
        rd_chk(1, 0, 32'h0000FFFF, "R4 lock first");
        wr(1, 0, 32'hFF000000, 0);
        rd_chk(1, 0, 32'hFF00FFFF, "R4 lock accumulate");
        wr(1, 0, 32'h0, 0);
        rd_chk(1, 0, 32'hFF00FFFF, "R4 lock not cleared");
        wr(0, 0, 32'hAAAAAAAA, 0);
        rd_chk(0, 0, 32'h12AA5678, "R5 locked merge");

        // R8: mask banks
        rd_chk(2, 0, 32'h0000FFFF, "R8 prov mask word0");
        rd_chk(3, 1, 32'h0F0F0F0F, "R8 dis mask word1");
        dis_mask_in  = '0;
        prov_mask_in = '1;
        wr(2, 0, 32'h12121212, 0);
        wr(3, 1, 32'h0, 0);
        rd_chk(2, 0, 32'h0000FFFF, "R8 prov mask held");
        rd_chk(3, 1, 32'h0F0F0F0F, "R8 dis mask held");

        // R9 / R6 / R7: write colliding with provisioning
        wr(0, 3, 32'h00000000, 1);
        rd_chk(0, 3, 32'h55555555, "R9 write dropped");
        rd_chk(0, 2, 32'hAAAAAAAA, "R7 word2 forced off");
        rd_chk(0, 1, 32'hA5A5A5A5, "R7 word1 pairs");
        rd_chk(0, 0, 32'h0000565A, "R6 word0 masked");
        bit_chk(err_o, 1'b1, "R9 err unchanged");

        // R6: a second pulse keeps the result stable
        pulse_prov();
        rd_chk(0, 0, 32'h0000565A, "R6 repeat word0");

        // R1 / R8: reset again, masks recaptured
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        rd_chk(0, 0, 32'h0, "R1 enable after rerun");
        rd_chk(1, 0, 32'h0, "R1 lock after rerun");
        bit_chk(err_o, 1'b0, "R1 err after rerun");
        rd_chk(3, 1, 32'h0, "R8 recapture dis mask");
        rd_chk(2, 2, 32'hFFFFFFFF, "R8 recapture prov mask");

        done = 1;
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule